// File: doc/BRIEF.md
# Raw-MAC Socket Command and Interrupt Unit

This unit sits between a host register port and the frame datapath of a single raw-MAC socket. The host writes a command code into the command register. The unit turns the code into a one-cycle action pulse towards the datapath (open, close, send or receive). The command register keeps reading non-zero until the datapath reports completion, so software can poll it to learn when the operation has finished. The unit also tracks whether the socket is open through a status register, and a socket mode register selects promiscuous or filtered raw-MAC operation.

Event pulses from the datapath (transmit finished, frame received) are gathered into a sticky flag register. The host clears that register by writing ones. A common mask bit decides whether any pending flag drives the active-low, level-sensitive interrupt pin.

Register offsets on the host port: 0 = socket mode, 1 = command, 2 = event flags, 3 = status, 4 = interrupt mask. Reads are combinational from the addressed register. Unused offsets read 0x00.

Top module: `sock_cmd_irq_unit`

## Requirements
- R1: After synchronous reset, every register reads 0x00, `irq_n` is 1 and no action pulse is active.
- R2: Writing 0x01 (OPEN) while the mode register holds 0x04 or 0x44 raises `act_open` for exactly the one cycle after the write edge. After the completion edge, status reads 0x42.
- R3: After a command starts an action, the command register reads the written code until the edge on which `op_done` is sampled high. From the next cycle it reads 0x00.
- R4: While status is 0x42, the codes 0x10 (CLOSE), 0x20 (SEND) and 0x40 (RECV) each raise their own pulse (`act_close`, `act_send`, `act_recv`) for one cycle. When a CLOSE completes, status returns to 0x00.
- R5: While status is 0x00, CLOSE, SEND and RECV raise no pulse. The command register reads the code for one cycle and then 0x00.
- R6: An unknown code, or OPEN with a mode value other than 0x04 or 0x44, raises no pulse and reads back for one cycle, then 0x00. Status is left unchanged.
- R7: A command write while the command register is non-zero is ignored: no pulse, and the register keeps its code.
- R8: An `ev_send_ok` pulse sets flag bit 0x10 and an `ev_rx` pulse sets flag bit 0x04 (offset 2), readable in the next cycle. The flags stay set until they are cleared.
- R9: Writing to offset 2 clears each flag whose bit is 1 in the written byte and keeps the others.
- R10: An event that arrives on the same edge as a write that clears its bit leaves that bit set.
- R11: `irq_n` is 0 exactly when mask bit 0 (offset 4) is 1 and at least one flag is set. With the mask at 0, `irq_n` stays 1.
- R12: The mode register reads back the last byte written to offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Byte read from the addressed register |
| op_done | input | 1 | Datapath completion of the pending action |
| ev_send_ok | input | 1 | Datapath event: transmit finished |
| ev_rx | input | 1 | Datapath event: frame received |
| act_open | output | 1 | One-cycle open request |
| act_close | output | 1 | One-cycle close request |
| act_send | output | 1 | One-cycle send request |
| act_recv | output | 1 | One-cycle receive-release request |
| irq_n | output | 1 | Level interrupt, active low |

## Verification
An action pulse and the new command readback both appear in the first cycle after the write edge. Completion becomes visible one cycle after the edge that samples `op_done`. A flag and the matching `irq_n` level appear one cycle after the event edge, because the pin is decoded from registered state. The bench drives inputs 1 ns after a rising edge and samples the read port and pins together at the following falling edge. Each expected item is queued in the cycle its result is due, so a result that comes a cycle early or late is compared against the wrong cycle and reported.

// File: rtl/sock_unit_pkg.sv
package sock_unit_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_EV = 2;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMD   = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd4;

    localparam logic [DATA_W-1:0] C_OPEN  = 8'h01;
    localparam logic [DATA_W-1:0] C_CLOSE = 8'h10;
    localparam logic [DATA_W-1:0] C_SEND  = 8'h20;
    localparam logic [DATA_W-1:0] C_RECV  = 8'h40;

    localparam logic [DATA_W-1:0] M_RAW_ALL  = 8'h04;
    localparam logic [DATA_W-1:0] M_RAW_FILT = 8'h44;

    localparam logic [DATA_W-1:0] S_CLOSED = 8'h00;
    localparam logic [DATA_W-1:0] S_RAW    = 8'h42;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_OPEN,
        ACT_CLOSE,
        ACT_SEND,
        ACT_RECV
    } act_e;

    typedef struct packed {
        logic open;
        logic close;
        logic send;
        logic recv;
    } act_pulse_t;

    // Event index to flag bit position: 0 -> send finished, 1 -> frame received
    function automatic int ev_bitpos(input int idx);
        case (idx)
            0:       return 4;
            1:       return 2;
            default: return 0;
        endcase
    endfunction

    function automatic act_e decode_cmd(input logic [DATA_W-1:0] code,
                                        input logic [DATA_W-1:0] mode,
                                        input logic              opened);
        act_e a;
        a = ACT_NONE;
        if (code == C_OPEN) begin
            if (mode == M_RAW_ALL || mode == M_RAW_FILT) a = ACT_OPEN;
        end else if (opened) begin
            if (code == C_CLOSE)     a = ACT_CLOSE;
            else if (code == C_SEND) a = ACT_SEND;
            else if (code == C_RECV) a = ACT_RECV;
        end
        return a;
    endfunction

    function automatic act_pulse_t act_to_pulse(input act_e a);
        act_pulse_t p;
        p       = '0;
        p.open  = (a == ACT_OPEN);
        p.close = (a == ACT_CLOSE);
        p.send  = (a == ACT_SEND);
        p.recv  = (a == ACT_RECV);
        return p;
    endfunction

endpackage

// File: rtl/sock_cmd_ctrl.sv
module sock_cmd_ctrl
    import sock_unit_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_we,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] mode_q,
    input  logic          op_done,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] status_q,
    output act_pulse_t    pulse_q
);

    act_e pend_q;
    logic quick_q;
    act_e dec;

    assign dec = decode_cmd(cmd_wdata, mode_q, status_q == S_RAW);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            status_q <= S_CLOSED;
            pend_q   <= ACT_NONE;
            quick_q  <= 1'b0;
            pulse_q  <= '0;
        end else begin
            pulse_q <= '0;
            if (cmd_q == '0) begin
                if (cmd_we) begin
                    cmd_q   <= cmd_wdata;
                    pulse_q <= act_to_pulse(dec);
                    pend_q  <= dec;
                    quick_q <= (dec == ACT_NONE);
                end
            end else if (quick_q) begin
                cmd_q   <= '0;
                quick_q <= 1'b0;
            end else if (op_done) begin
                cmd_q  <= '0;
                pend_q <= ACT_NONE;
                if (pend_q == ACT_OPEN)  status_q <= S_RAW;
                if (pend_q == ACT_CLOSE) status_q <= S_CLOSED;
            end
        end
    end

    // R4: at most one action at a time
    p_one_action_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse_q));

    // R2: a pulse lasts one cycle
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        (|pulse_q) |=> !(|pulse_q));

    // R3: the command register is busy whenever an action is issued
    p_busy_on_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (|pulse_q) |-> (cmd_q != '0));

    // R2: status moves only on a completion
    p_status_on_done_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_q) |-> $past(op_done));

endmodule

// File: rtl/sock_evt_flags.sv
module sock_evt_flags
    import sock_unit_pkg::*;
#(
    parameter int NEV = NUM_EV
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_we,
    input  logic [NEV-1:0] clr_sel,
    input  logic [NEV-1:0] ev,
    output logic [NEV-1:0] flag_q
);

    for (genvar i = 0; i < NEV; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= (flag_q[i] & ~(clr_we & clr_sel[i])) | ev[i];
        end

        // R10: an event always leaves its flag set
        p_evt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> flag_q[i]);

        // R9: a clearing write with no event drops the flag
        p_w1c_clear_r9: assert property (@(posedge clk) disable iff (rst)
            (clr_we && clr_sel[i] && !ev[i]) |=> !flag_q[i]);
    end

endmodule

// File: rtl/sock_irq_out.sv
module sock_irq_out
    import sock_unit_pkg::*;
#(
    parameter int NEV = NUM_EV
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mask_en,
    input  logic [NEV-1:0] flags,
    output logic           irq_n
);

    assign irq_n = ~(mask_en & (|flags));

    // R11: a cleared mask keeps the pin inactive
    p_mask_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !mask_en |-> irq_n);

    // R11: with no flag pending the pin is inactive
    p_no_flag_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> irq_n);

endmodule

// File: rtl/sock_cmd_irq_unit.sv
module sock_cmd_irq_unit
    import sock_unit_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int NEV = NUM_EV
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          op_done,
    input  logic          ev_send_ok,
    input  logic          ev_rx,
    output logic          act_open,
    output logic          act_close,
    output logic          act_send,
    output logic          act_recv,
    output logic          irq_n
);

    logic [DW-1:0]  mode_q;
    logic           mask_q;
    logic [DW-1:0]  cmd_q;
    logic [DW-1:0]  status_q;
    act_pulse_t     pulse;
    logic [NEV-1:0] flag_q;
    logic [NEV-1:0] clr_sel;
    logic [NEV-1:0] ev_vec;
    logic [DW-1:0]  flag_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == A_MODE) mode_q <= reg_wdata;
            if (reg_addr == A_MASK) mask_q <= reg_wdata[0];
        end
    end

    assign ev_vec = NEV'({ev_rx, ev_send_ok});

    always_comb begin
        clr_sel   = '0;
        flag_byte = '0;
        for (int i = 0; i < NEV; i++) begin
            clr_sel[i]              = reg_wdata[ev_bitpos(i)];
            flag_byte[ev_bitpos(i)] = flag_q[i];
        end
    end

    sock_cmd_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (reg_we && reg_addr == A_CMD),
        .cmd_wdata (reg_wdata),
        .mode_q    (mode_q),
        .op_done   (op_done),
        .cmd_q     (cmd_q),
        .status_q  (status_q),
        .pulse_q   (pulse)
    );

    sock_evt_flags #(.NEV(NEV)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_we  (reg_we && reg_addr == A_FLAGS),
        .clr_sel (clr_sel),
        .ev      (ev_vec),
        .flag_q  (flag_q)
    );

    sock_irq_out #(.NEV(NEV)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_en (mask_q),
        .flags   (flag_q),
        .irq_n   (irq_n)
    );

    assign act_open  = pulse.open;
    assign act_close = pulse.close;
    assign act_send  = pulse.send;
    assign act_recv  = pulse.recv;

    always_comb begin
        case (reg_addr)
            A_MODE:  reg_rdata = mode_q;
            A_CMD:   reg_rdata = cmd_q;
            A_FLAGS: reg_rdata = flag_byte;
            A_STAT:  reg_rdata = status_q;
            A_MASK:  reg_rdata = {{(DW-1){1'b0}}, mask_q};
            default: reg_rdata = '0;
        endcase
    end

    // R12: the mode register follows a write to its offset
    p_mode_write_r12: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_MODE) |=> (mode_q == $past(reg_wdata)));

endmodule

// File: tb/sim_sock_cmd_irq_unit.sv
module sim_sock_cmd_irq_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       op_done = 1'b0;
    logic       ev_send_ok = 1'b0;
    logic       ev_rx = 1'b0;
    logic       act_open, act_close, act_send, act_recv, irq_n;

    always #2 clk = ~clk;

    sock_cmd_irq_unit u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_done(op_done),
        .ev_send_ok(ev_send_ok), .ev_rx(ev_rx), .act_open(act_open),
        .act_close(act_close), .act_send(act_send), .act_recv(act_recv),
        .irq_n(irq_n)
    );

    localparam logic [2:0] MODE = 3'd0, CMD = 3'd1, FLG = 3'd2, STA = 3'd3, MSK = 3'd4;
    // pin vector {irq_n, open, close, send, recv}
    localparam logic [4:0] IDLE = 5'b10000, P_OP = 5'b11000, P_CL = 5'b10100,
                           P_SD = 5'b10010, P_RV = 5'b10001, LOW = 5'b00000;

    typedef struct {
        logic [7:0] rd;
        logic [4:0] pins;
        string      tag;
    } exp_t;

    exp_t q[$];
    logic chk = 1'b0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    // monitor: compare the queued expectation with the outputs
    always @(negedge clk) begin
        if (chk) begin
            exp_t e;
            logic [4:0] got;
            got = {irq_n, act_open, act_close, act_send, act_recv};
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty");
            end else begin
                e = q.pop_front();
                if (reg_rdata !== e.rd || got !== e.pins) begin
                    bad++;
                    $display("FAIL %s: rdata=%02h pins=%05b expected rdata=%02h pins=%05b",
                             e.tag, reg_rdata, got, e.rd, e.pins);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic check(input logic [2:0] a, input logic [7:0] rd,
                         input logic [4:0] pins, input string tag);
        exp_t e;
        e.rd = rd; e.pins = pins; e.tag = tag;
        reg_addr = a;
        q.push_back(e);
        chk = 1'b1;
        tick();
        chk = 1'b0;
    endtask

    task automatic done_pulse();
        op_done = 1'b1;
        tick();
        op_done = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        check(MODE, 8'h00, IDLE, "R1 mode");
        check(CMD,  8'h00, IDLE, "R1 cmd");
        check(FLG,  8'h00, IDLE, "R1 flags");
        check(STA,  8'h00, IDLE, "R1 status");
        check(MSK,  8'h00, IDLE, "R1 mask");

        // R12 mode readback
        wr(MODE, 8'h44);
        check(MODE, 8'h44, IDLE, "R12 mode");

        // R5 send while closed
        wr(CMD, 8'h20);
        check(CMD, 8'h20, IDLE, "R5 closed send held");
        check(CMD, 8'h00, IDLE, "R5 closed send done");

        // R6 unknown code while closed
        wr(CMD, 8'h07);
        check(CMD, 8'h07, IDLE, "R6 unknown held");
        check(CMD, 8'h00, IDLE, "R6 unknown done");

        // R2 R3 open filtered
        wr(CMD, 8'h01);
        check(CMD, 8'h01, P_OP, "R2 open pulse");
        check(CMD, 8'h01, IDLE, "R3 busy");
        check(STA, 8'h00, IDLE, "R2 status before done");
        done_pulse();
        check(CMD, 8'h00, IDLE, "R3 cleared");
        check(STA, 8'h42, IDLE, "R2 status open");

        // R4 R7 send, busy write ignored
        wr(CMD, 8'h20);
        check(CMD, 8'h20, P_SD, "R4 send pulse");
        wr(CMD, 8'h40);
        check(CMD, 8'h20, IDLE, "R7 busy write ignored");
        done_pulse();
        check(CMD, 8'h00, IDLE, "R3 send done");

        // R4 recv
        wr(CMD, 8'h40);
        check(CMD, 8'h40, P_RV, "R4 recv pulse");
        done_pulse();
        check(CMD, 8'h00, IDLE, "R3 recv done");

        // R6 unknown while open
        wr(CMD, 8'h07);
        check(CMD, 8'h07, IDLE, "R6 unknown open held");
        check(CMD, 8'h00, IDLE, "R6 unknown open done");
        check(STA, 8'h42, IDLE, "R6 status kept");

        // R4 close
        wr(CMD, 8'h10);
        check(CMD, 8'h10, P_CL, "R4 close pulse");
        done_pulse();
        check(STA, 8'h00, IDLE, "R4 status closed");

        // R6 open with an unsupported mode
        wr(MODE, 8'h01);
        wr(CMD, 8'h01);
        check(CMD, 8'h01, IDLE, "R6 bad mode held");
        check(CMD, 8'h00, IDLE, "R6 bad mode done");
        check(STA, 8'h00, IDLE, "R6 bad mode status");

        // R2 open promiscuous
        wr(MODE, 8'h04);
        check(MODE, 8'h04, IDLE, "R12 mode 04");
        wr(CMD, 8'h01);
        check(CMD, 8'h01, P_OP, "R2 open pulse promisc");
        done_pulse();
        check(STA, 8'h42, IDLE, "R2 status promisc");

        // R8 R11 event with mask off
        ev_send_ok = 1'b1; tick(); ev_send_ok = 1'b0;
        check(FLG, 8'h10, IDLE, "R8 R11 sendok masked");
        wr(MSK, 8'h01);
        check(MSK, 8'h01, LOW, "R11 mask on");
        ev_rx = 1'b1; tick(); ev_rx = 1'b0;
        check(FLG, 8'h14, LOW, "R8 rx flag");

        // R9 clear one bit
        wr(FLG, 8'h10);
        check(FLG, 8'h04, LOW, "R9 partial clear");

        // R10 event with clear on the same edge
        ev_rx = 1'b1;
        wr(FLG, 8'h04);
        ev_rx = 1'b0;
        check(FLG, 8'h04, LOW, "R10 event wins");

        wr(FLG, 8'hFF);
        check(FLG, 8'h00, IDLE, "R9 R11 all cleared");

        ev_send_ok = 1'b1; tick(); ev_send_ok = 1'b0;
        check(FLG, 8'h10, LOW, "R11 pin low");
        wr(MSK, 8'h00);
        check(FLG, 8'h10, IDLE, "R11 mask off quiet");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule